// File: doc/BRIEF.md
# Dual-Bank Prioritised Interrupt Controller

This block gathers up to 32 interrupt sources and presents them to a processor on two request lines. One is the normal request line and the other is the fast request line. Every source passes through a shared front end before either bank sees it. The front end first applies a per-source polarity choice. It then either passes the level straight through or latches it until the source is acknowledged. Each source also carries a 4-bit priority, where a lower value means more urgent.

Each of the two banks has its own enable mask and its own priority threshold. A bank forms its masked pending vector from these and drives its line as the OR of that vector. Through a current-source register it reports the most urgent qualifying source. Reading that bank's acknowledge register releases the latch of the reported source.

Software reaches all of this through a single-cycle register port. Writes take effect at the clock edge that samples them. Read data is registered and appears after the same edge. A handler typically polls the masked status word until it reads zero. Each time round, it reads the current register or the acknowledge register to obtain the source number it must service.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset, every enable mask is 0, both thresholds are 0, all priorities are 0, all sources are level-captured, and the polarity word reads 0xFFFFFFFF (no inversion). Both request lines are low.
- R2: Within a bank, writing to offset 0x08 sets the enable bits given by ones in the write data, and writing to offset 0x0C clears them. Zero bits leave their enables unchanged. Reading either offset returns the enable mask.
- R3: The polarity word sits at 0x200. When bit i is 1, source i is taken as-is; when it is 0, source i is inverted. Raw status at bank offset 0x04 returns the captured vector after polarity and capture, regardless of enables and threshold.
- R4: The capture-mode word sits at 0x204. When bit i is 1, source i is latched from its first active cycle until it is acknowledged. When it is 0, source i follows its input level. Writing 0 to the word returns every source to level capture.
- R5: Each bank has a 4-bit threshold at offset 0x2C. A source qualifies only when its priority value is less than or equal to the threshold. A threshold of 0xF admits every priority.
- R6: Masked status at bank offset 0x00 is the captured vector ANDed with the bank's enables and with threshold qualification. The bank's request line is high exactly when that word is nonzero.
- R7: The current register at bank offset 0x20 returns the index of the qualifying source with the smallest priority value. On a tie, the lowest index wins. When no source qualifies, it returns 0.
- R8: Reading bank offset 0x28 returns the same number as the current register and clears the latch of that source only. Level-captured sources are unaffected. A write to 0x28 has no effect.
- R9: The normal bank is at base 0x000 and the fast bank at base 0x100. Both banks see the same captured sources but hold separate enables and thresholds.
- R10: The priority of source i is held in bits [3:0] of the word at 0x300 + 4*i. Those bits read back, and the upper bits read as zero.
- R11: Unmapped offsets read as zero. This includes priority words for indices of 32 or more (0x380 and above), and a write to such a word changes no priority.
- R12: Read data changes only on the clock edge that samples a read request and holds at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt source inputs |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal request line |
| fiq_o | output | 1 | Fast request line |

## Verification
A level-captured source reaches raw status, masked status and the request lines combinationally, so results are due within the same cycle. A latched source needs one clock edge before it appears. Register writes and the acknowledge clear take effect at the edge that samples the request. Read data appears after that same edge. The bench therefore drives stimulus on the falling edge, lets one rising edge pass for any access, and samples outputs on the next falling edge. Checks on the request lines are made a short delay after a source change.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam logic [7:0] OFS_MSTAT  = 8'h00;
  localparam logic [7:0] OFS_RAW    = 8'h04;
  localparam logic [7:0] OFS_EN_SET = 8'h08;
  localparam logic [7:0] OFS_EN_CLR = 8'h0C;
  localparam logic [7:0] OFS_CUR    = 8'h20;
  localparam logic [7:0] OFS_ACK    = 8'h28;
  localparam logic [7:0] OFS_THR    = 8'h2C;
  localparam logic [7:0] OFS_POL    = 8'h00;
  localparam logic [7:0] OFS_STICKY = 8'h04;

  typedef enum logic [1:0] {
    BLK_NORM   = 2'd0,
    BLK_FAST   = 2'd1,
    BLK_SHARED = 2'd2,
    BLK_PRIO   = 2'd3
  } blk_e;
endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] sticky_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pol_src;
  logic [N-1:0] latch_q;

  assign pol_src = src_i ^ ~pol_i;

  // set beats clear so a still-active input relatches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else         latch_q <= ((latch_q & ~clr_i) | pol_src) & sticky_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign pend_o[i] = sticky_i[i] ? latch_q[i] : pol_src[i];
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 4,
  parameter int unsigned DW = 32,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N-1:0]          pend_i,
  input  logic [N-1:0][PW-1:0]  prio_i,
  input  logic                  set_we_i,
  input  logic                  clr_we_i,
  input  logic                  thr_we_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [N-1:0]          en_o,
  output logic [PW-1:0]         thr_o,
  output logic [N-1:0]          qual_o,
  output logic [IW-1:0]         cur_o,
  output logic                  line_o
);
  logic [N-1:0]  en_q;
  logic [PW-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      thr_q <= '0;
    end else begin
      if (set_we_i) en_q <= en_q | wdata_i[N-1:0];
      if (clr_we_i) en_q <= en_q & ~wdata_i[N-1:0];
      if (thr_we_i) thr_q <= wdata_i[PW-1:0];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_qual
    assign qual_o[i] = pend_i[i] & en_q[i] & (prio_i[i] <= thr_q);
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    logic          found;
    logic [PW-1:0] best;
    found = 1'b0;
    best  = '0;
    cur_o = '0;
    for (int i = 0; i < N; i++) begin
      if (qual_o[i] && (!found || prio_i[i] < best)) begin
        found = 1'b1;
        best  = prio_i[i];
        cur_o = IW'(i);
      end
    end
  end

  assign en_o   = en_q;
  assign thr_o  = thr_q;
  assign line_o = |qual_o;
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o,
  output logic                fiq_o
);
  import intc_pkg::*;

  localparam int unsigned IDX_W    = $clog2(NUM_SRC);
  localparam int unsigned NUM_BANK = 2;

  logic                         wr, rd, top_ok;
  blk_e                         blk;
  logic [7:0]                   ofs;
  logic [5:0]                   pidx;
  logic                         prio_hit;

  logic [NUM_SRC-1:0]           pol_q, stk_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]           pend;
  logic [NUM_SRC-1:0]           clr_all;
  logic [DATA_W-1:0]            rd_val, rdata_q;

  logic [NUM_SRC-1:0]           bank_en   [NUM_BANK];
  logic [PRIO_W-1:0]            bank_thr  [NUM_BANK];
  logic [NUM_SRC-1:0]           bank_qual [NUM_BANK];
  logic [IDX_W-1:0]             bank_cur  [NUM_BANK];
  logic [NUM_BANK-1:0]          bank_line;
  logic [NUM_BANK-1:0]          bank_hit;
  logic [NUM_SRC-1:0]           ack_clr   [NUM_BANK];

  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign top_ok   = (addr_i[ADDR_W-1:10] == '0);
  assign blk      = blk_e'(addr_i[9:8]);
  assign ofs      = addr_i[7:0];
  assign pidx     = addr_i[7:2];
  assign prio_hit = top_ok && (blk == BLK_PRIO) && (addr_i[1:0] == 2'b00)
                    && (32'(pidx) < NUM_SRC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= '1;
      stk_q  <= '0;
      prio_q <= '0;
    end else if (wr && top_ok) begin
      if (blk == BLK_SHARED && ofs == OFS_POL)    pol_q <= wdata_i[NUM_SRC-1:0];
      if (blk == BLK_SHARED && ofs == OFS_STICKY) stk_q <= wdata_i[NUM_SRC-1:0];
      if (prio_hit) prio_q[pidx[IDX_W-1:0]] <= wdata_i[PRIO_W-1:0];
    end
  end

  intc_capture #(.N(NUM_SRC)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .pol_i    (pol_q),
    .sticky_i (stk_q),
    .clr_i    (clr_all),
    .pend_o   (pend)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    assign bank_hit[b] = top_ok && (addr_i[9:8] == 2'(b));

    intc_bank #(.N(NUM_SRC), .PW(PRIO_W), .DW(DATA_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pend_i   (pend),
      .prio_i   (prio_q),
      .set_we_i (wr && bank_hit[b] && ofs == OFS_EN_SET),
      .clr_we_i (wr && bank_hit[b] && ofs == OFS_EN_CLR),
      .thr_we_i (wr && bank_hit[b] && ofs == OFS_THR),
      .wdata_i  (wdata_i),
      .en_o     (bank_en[b]),
      .thr_o    (bank_thr[b]),
      .qual_o   (bank_qual[b]),
      .cur_o    (bank_cur[b]),
      .line_o   (bank_line[b])
    );

    assign ack_clr[b] = (rd && bank_hit[b] && ofs == OFS_ACK && bank_line[b])
                        ? (NUM_SRC'(1) << bank_cur[b]) : '0;
  end

  assign clr_all = ack_clr[0] | ack_clr[1];

  always_comb begin
    rd_val = '0;
    if (top_ok) begin
      unique case (blk)
        BLK_NORM, BLK_FAST: begin
          case (ofs)
            OFS_MSTAT:            rd_val = DATA_W'(bank_qual[blk[0]]);
            OFS_RAW:              rd_val = DATA_W'(pend);
            OFS_EN_SET, OFS_EN_CLR: rd_val = DATA_W'(bank_en[blk[0]]);
            OFS_CUR, OFS_ACK:     rd_val = DATA_W'(bank_cur[blk[0]]);
            OFS_THR:              rd_val = DATA_W'(bank_thr[blk[0]]);
            default:              rd_val = '0;
          endcase
        end
        BLK_SHARED: begin
          if (ofs == OFS_POL)         rd_val = DATA_W'(pol_q);
          else if (ofs == OFS_STICKY) rd_val = DATA_W'(stk_q);
        end
        BLK_PRIO: if (prio_hit) rd_val = DATA_W'(prio_q[pidx[IDX_W-1:0]]);
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = bank_line[0];
  assign fiq_o   = bank_line[1];
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 4,
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_o,
  input logic [N-1:0]  irq_en_i,
  input logic [N-1:0]  fiq_en_i,
  input logic [PW-1:0] irq_thr_i
);
  p_en_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'('h008)) |=>
      ((irq_en_i & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])));

  p_en_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'('h00C)) |=>
      ((irq_en_i & $past(wdata_i[N-1:0])) == '0));

  p_thr_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'('h02C)) |=> (irq_thr_i == $past(wdata_i[PW-1:0])));

  p_no_line_unenabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !irq_o);

  p_bank_indep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[AW-1:8] == '0) |=> $stable(fiq_en_i));

  p_rdata_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

bind dual_bank_intc intc_checker #(
  .N(NUM_SRC), .PW(PRIO_W), .AW(ADDR_W), .DW(DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .irq_en_i  (bank_en[0]),
  .fiq_en_i  (bank_en[1]),
  .irq_thr_i (bank_thr[0])
);

// File: tb/dual_bank_intc_test.sv
module dual_bank_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #5 clk = ~clk;

  dual_bank_intc uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src = '0; req = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk);
    src = v;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 irq line", 32'(irq), 0);
    chk("R1 fiq line", 32'(fiq), 0);
    rd(12'h008, d); chk("R1 enable", d, 0);
    rd(12'h02C, d); chk("R1 threshold", d, 0);
    rd(12'h200, d); chk("R1 polarity", d, 32'hFFFF_FFFF);
    rd(12'h204, d); chk("R1 sticky", d, 0);
    rd(12'h37C, d); chk("R1 priority", d, 0);
  endtask

  task automatic t_enable_mask();
    logic [31:0] d;
    do_reset();
    wr(12'h008, 32'h0000_00F0);
    wr(12'h00C, 32'h0000_0030);
    rd(12'h008, d); chk("R2 set/clear", d, 32'h0000_00C0);
    rd(12'h00C, d); chk("R2 clear readback", d, 32'h0000_00C0);
    rd(12'h108, d); chk("R9 fast enables untouched", d, 0);
    set_src(32'h0000_0041);
    chk("R6 irq line", 32'(irq), 1);
    chk("R9 fiq line idle", 32'(fiq), 0);
    rd(12'h000, d); chk("R6 masked status", d, 32'h0000_0040);
    rd(12'h004, d); chk("R3 raw status", d, 32'h0000_0041);
    rd(12'h020, d); chk("R7 current", d, 6);
    wr(12'h00C, 32'h0000_0040);
    #1 chk("R6 line drops", 32'(irq), 0);
  endtask

  task automatic t_polarity();
    logic [31:0] d;
    do_reset();
    set_src(32'h0000_0041);
    rd(12'h000, d); chk("R6 unenabled masked", d, 0);
    wr(12'h200, 32'hFFFF_FFFE);
    rd(12'h004, d); chk("R3 inverted high", d, 32'h0000_0040);
    set_src(32'h0);
    rd(12'h004, d); chk("R3 inverted low", d, 32'h0000_0001);
    rd(12'h200, d); chk("R3 readback", d, 32'hFFFF_FFFE);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    do_reset();
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'h30C, 2); wr(12'h314, 1); wr(12'h324, 1);
    set_src(32'h0000_0228);
    chk("R5 blocked line", 32'(irq), 0);
    rd(12'h000, d); chk("R5 threshold 0", d, 0);
    rd(12'h020, d); chk("R7 none qualifies", d, 0);
    wr(12'h02C, 1);
    rd(12'h000, d); chk("R5 threshold 1", d, 32'h0000_0220);
    rd(12'h020, d); chk("R7 tie lowest index", d, 5);
    wr(12'h02C, 32'hFFFF_FFFF);
    rd(12'h02C, d); chk("R5 threshold field", d, 32'hF);
    rd(12'h000, d); chk("R5 threshold F", d, 32'h0000_0228);
    wr(12'h30C, 0);
    rd(12'h020, d); chk("R7 smaller value wins", d, 3);
    rd(12'h314, d); chk("R10 priority readback", d, 1);
    wr(12'h314, 32'hFFFF_FFF7);
    rd(12'h314, d); chk("R10 field width", d, 7);
  endtask

  task automatic t_sticky_ack();
    logic [31:0] d;
    do_reset();
    wr(12'h204, 32'h0000_0014);
    wr(12'h008, 32'h0000_0094);
    wr(12'h02C, 32'hF);
    set_src(32'h0000_0004);
    set_src(32'h0000_0080);
    rd(12'h004, d); chk("R4 latched pulse", d, 32'h0000_0084);
    rd(12'h028, d); chk("R8 ack returns source", d, 2);
    rd(12'h004, d); chk("R8 latch released", d, 32'h0000_0080);
    rd(12'h028, d); chk("R8 ack level source", d, 7);
    rd(12'h004, d); chk("R8 level unaffected", d, 32'h0000_0080);
    set_src(32'h0000_0090);
    set_src(32'h0000_0080);
    wr(12'h028, 32'hFFFF_FFFF);
    rd(12'h004, d); chk("R8 write is no ack", d, 32'h0000_0090);
    rd(12'h204, d); chk("R4 readback", d, 32'h0000_0014);
    wr(12'h204, 0);
    rd(12'h004, d); chk("R4 back to level", d, 32'h0000_0080);
  endtask

  task automatic t_fast_bank();
    logic [31:0] d;
    do_reset();
    wr(12'h108, 32'h0000_0002);
    set_src(32'h0000_0002);
    chk("R9 fiq line", 32'(fiq), 1);
    chk("R9 irq line", 32'(irq), 0);
    rd(12'h100, d); chk("R9 fast masked", d, 2);
    rd(12'h000, d); chk("R9 normal masked", d, 0);
    rd(12'h120, d); chk("R9 fast current", d, 1);
    rd(12'h128, d); chk("R9 fast ack", d, 1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    do_reset();
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h010, d); chk("R11 bank hole", d, 0);
    rd(12'h400, d); chk("R11 above map", d, 0);
    wr(12'h380, 5);
    rd(12'h380, d); chk("R11 priority out of range", d, 0);
    rd(12'h300, d); chk("R11 no alias", d, 0);
    @(negedge clk);
    d = rdata;
    repeat (3) @(negedge clk);
    chk("R12 rdata holds", rdata, d);
  endtask

  initial begin
    t_reset();
    t_enable_mask();
    t_polarity();
    t_priority();
    t_sticky_ack();
    t_fast_bank();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule